// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources, folds them onto a smaller set of vectors, and picks one winning vector to present to the processor. Each source has its own enable bit and its own request flag. A request flag is set by a one-cycle peripheral event pulse, or, for the first few sources, by a chosen edge on an external pin. Software clears a flag once its handler is done. Each vector carries a 5-bit priority made of a main level and a sub-level. The winner is raised to the processor only when its main level is strictly above the level the processor is running at. Any request held back this way stays pending and goes out once the processor level drops.

A small register port (write strobe, address, write data, combinational read data) reaches the enables, the flags, a control word and the per-vector priorities. A mode bit selects whether the block always reports vector 0 (single-vector mode, the reset state) or the number of the winning vector.

Top module: `vpic_top`

## Requirements
- R1: After reset all enable bits, request flags, control bits (mode and pin polarities) and priority fields are 0, and irq_valid_o, irq_vec_o and irq_level_o are 0.
- R2: irq_valid_o is 1 only when some source is enabled and flagged and its vector's main level is strictly greater than cpu_prio_i. With equal levels, irq_valid_o is 0.
- R3: A request held back by cpu_prio_i stays pending: its flag stays set, and irq_valid_o rises once cpu_prio_i falls below the vector's main level.
- R4: A vector whose main level (priority bits [4:2]) is 0 never wins and never raises irq_valid_o, whatever its sub-level.
- R5: Among active vectors, a higher main level wins. On equal main levels, a higher sub-level (priority bits [1:0]) wins. On a full tie, the lower vector index wins.
- R6: Source s maps to vector floor(s*NVEC/NSRC), which is s/2 with the defaults. A vector is active when any of its mapped sources is both enabled and flagged.
- R7: A flag is set by a one-cycle pulse on evt_i. Writing to address 1 clears the flags at the 1 bits of the write data, and such a write never sets a flag. If a clear and a set hit the same flag in the same cycle, the flag ends up set.
- R8: Control bit 0 at address 2 selects the mode: 0 always reports vector 0, and 1 reports the winning vector's number.
- R9: Each external pin p, after a two-flop synchronizer, sets the flag of source p on a rising edge when control bit p+1 is 1, and on a falling edge when that bit is 0.
- R10: The register map is: address 0 holds the enables, address 1 the flags (write 1 to clear), address 2 the control word, and address 3+v the priority of vector v. Outputs are registered, so a change of register state appears on the outputs one clock later, and irq_level_o carries the winner's main level (0 when there is no winner).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Register write data |
| rd_data_o | output | DW | Read data for addr_i (combinational) |
| evt_i | input | NSRC | One-cycle peripheral event pulses, one per source |
| ext_pin_i | input | NEXT | Asynchronous external interrupt pins |
| cpu_prio_i | input | 3 | Level the processor currently runs at |
| irq_valid_o | output | 1 | Request to the processor |
| irq_vec_o | output | VW | Vector reported to the processor |
| irq_level_o | output | 3 | Winner's main level |

## Verification
An event pulse or a register write changes register state at one clock edge, and the outputs follow at the next edge. A change on cpu_prio_i shows up at the first edge. A pin edge needs two synchronizer stages and one edge-detect flop before it sets the flag, and then one more edge before the outputs change. The bench holds every input steady for at least four clocks (six after a pin change) and samples on the falling edge. One directed check samples exactly one and two clocks after an enable write, to pin down the single-register output latency.

// File: rtl/vpic_pkg.sv
// Package: shared types and helpers for the vectored priority interrupt controller.
// Assumes: register addresses fit the AW chosen at the top level.
package vpic_pkg;

    // Vector priority: main level in the upper bits, sub-level below, so a
    // plain unsigned compare of the packed value orders main first, then sub.
    typedef struct packed {
        logic [2:0] main;
        logic [1:0] sub;
    } prio_t;

    localparam int ADR_ENABLE = 0;
    localparam int ADR_FLAGS  = 1;
    localparam int ADR_CTRL   = 2;
    localparam int ADR_PRIO0  = 3;

    // Fixed source-to-vector folding.
    function automatic int vec_of(input int src, input int nsrc, input int nvec);
        return (src * nvec) / nsrc;
    endfunction

endpackage

// File: rtl/vpic_extsync.sv
// Module: synchronizes external pins and turns the selected edge into a
// one-cycle event pulse per pin.
// Assumes: pins are asynchronous; rise_sel_i is a quasi-static control bit.
module vpic_extsync #(
    parameter int NEXT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] pin_i,
    input  logic [NEXT-1:0] rise_sel_i,
    output logic [NEXT-1:0] evt_o
);
    for (genvar p = 0; p < NEXT; p++) begin : g_pin
        logic meta_q, sync_q, last_q;
        logic rise_w, fall_w;

        // Two-flop synchronizer plus one delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= pin_i[p];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        // Edge decode and polarity select.
        always_comb begin
            rise_w   = sync_q & ~last_q;
            fall_w   = ~sync_q & last_q;
            evt_o[p] = rise_sel_i[p] ? rise_w : fall_w;
        end

        AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_w |=> !rise_w); // R9
    end
endmodule

// File: rtl/vpic_regs.sv
// Module: register file holding enables, request flags, control word and
// per-vector priorities; combinational read mux.
// Assumes: NSRC <= DW and NEXT+1 <= DW; flags are write-1-to-clear, and a
// same-cycle set wins over a clear.
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NVEC = 8,
    parameter int NEXT = 5,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic [NSRC-1:0]        set_i,
    output logic [NSRC-1:0]        en_o,
    output logic [NSRC-1:0]        flg_o,
    output prio_t [NVEC-1:0]       prio_o,
    output logic                   mode_o,
    output logic [NEXT-1:0]        rise_sel_o,
    output logic [DW-1:0]          rd_data_o
);
    logic [NSRC-1:0] clr_w;
    logic            wr_en_w, wr_flg_w, wr_ctl_w;

    // Address decode of the write strobe.
    always_comb begin
        wr_en_w  = wr_en_i && (addr_i == AW'(ADR_ENABLE));
        wr_flg_w = wr_en_i && (addr_i == AW'(ADR_FLAGS));
        wr_ctl_w = wr_en_i && (addr_i == AW'(ADR_CTRL));
        clr_w    = wr_flg_w ? wdata_i[NSRC-1:0] : '0;
    end

    // Enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (wr_en_w) en_o <= wdata_i[NSRC-1:0];
    end

    // Request flags: event set dominates a same-cycle software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_o <= '0;
        else        flg_o <= (flg_o & ~clr_w) | set_i;
    end

    // Control word: mode bit and pin edge polarities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o     <= 1'b0;
            rise_sel_o <= '0;
        end else if (wr_ctl_w) begin
            mode_o     <= wdata_i[0];
            rise_sel_o <= wdata_i[NEXT:1];
        end
    end

    for (genvar v = 0; v < NVEC; v++) begin : g_prio
        // Priority field of one vector.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_o[v] <= '0;
            else if (wr_en_i && addr_i == AW'(ADR_PRIO0 + v))
                prio_o[v] <= prio_t'(wdata_i[4:0]);
        end
    end

    // Read mux.
    always_comb begin
        rd_data_o = '0;
        if (addr_i == AW'(ADR_ENABLE)) rd_data_o[NSRC-1:0] = en_o;
        if (addr_i == AW'(ADR_FLAGS))  rd_data_o[NSRC-1:0] = flg_o;
        if (addr_i == AW'(ADR_CTRL))   rd_data_o[NEXT:0]   = {rise_sel_o, mode_o};
        for (int v = 0; v < NVEC; v++)
            if (addr_i == AW'(ADR_PRIO0 + v)) rd_data_o[4:0] = prio_o[v];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flg_o & $past(set_i)) == $past(set_i))); // R7
    AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((flg_o & ~$past(flg_o)) == '0)); // R7
endmodule

// File: rtl/vpic_arbiter.sv
// Module: folds sources onto vectors and picks the winner: highest main
// level, then highest sub-level, then lowest vector index.
// Assumes: purely combinational; main level 0 disables a vector.
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NVEC = 8,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic [NSRC-1:0]  en_i,
    input  logic [NSRC-1:0]  flg_i,
    input  prio_t [NVEC-1:0] prio_i,
    output logic             found_o,
    output logic [VW-1:0]    win_vec_o,
    output prio_t            win_prio_o
);
    logic [NVEC-1:0] active_w;

    // Vector activity: any mapped source both enabled and flagged.
    always_comb begin
        active_w = '0;
        for (int s = 0; s < NSRC; s++)
            if (en_i[s] && flg_i[s])
                active_w[vec_of(s, NSRC, NVEC)] = 1'b1;
    end

    // Linear scan; strict compare keeps the lower index on a full tie.
    always_comb begin
        found_o    = 1'b0;
        win_vec_o  = '0;
        win_prio_o = '0;
        for (int v = 0; v < NVEC; v++) begin
            if (active_w[v] && prio_i[v].main != 3'd0 &&
                (!found_o || prio_i[v] > win_prio_o)) begin
                found_o    = 1'b1;
                win_vec_o  = VW'(v);
                win_prio_o = prio_i[v];
            end
        end
    end

    for (genvar v = 0; v < NVEC; v++) begin : g_chk
        // Every eligible vector ranks no higher than the winner.
        always_comb begin
            if (active_w[v] && prio_i[v].main != 3'd0)
                AST_WINNER_IS_MAX: assert (found_o && prio_i[v] <= win_prio_o); // R5
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Module: vectored priority interrupt controller top. Combines the register
// file, pin edge detection and arbiter, and registers the request outputs
// against the processor's current level.
// Assumes: NVEC + 3 addresses fit in AW bits; NEXT <= NSRC.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NVEC = 8,
    parameter int NEXT = 5,
    parameter int AW   = 4,
    parameter int DW   = 32,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rd_data_o,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NEXT-1:0] ext_pin_i,
    input  logic [2:0]      cpu_prio_i,
    output logic            irq_valid_o,
    output logic [VW-1:0]   irq_vec_o,
    output logic [2:0]      irq_level_o
);
    logic [NSRC-1:0]  en_w, flg_w, set_w;
    prio_t [NVEC-1:0] prio_w;
    logic             mode_w;
    logic [NEXT-1:0]  rise_sel_w, pin_evt_w;
    logic             found_w;
    logic [VW-1:0]    win_vec_w;
    prio_t            win_prio_w;

    vpic_extsync #(.NEXT(NEXT)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin_i),
        .rise_sel_i (rise_sel_w),
        .evt_o      (pin_evt_w)
    );

    // Flag set sources: peripheral pulses plus pin edges on the low sources.
    always_comb begin
        set_w = evt_i;
        set_w[NEXT-1:0] = evt_i[NEXT-1:0] | pin_evt_w;
    end

    vpic_regs #(.NSRC(NSRC), .NVEC(NVEC), .NEXT(NEXT), .AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .set_i      (set_w),
        .en_o       (en_w),
        .flg_o      (flg_w),
        .prio_o     (prio_w),
        .mode_o     (mode_w),
        .rise_sel_o (rise_sel_w),
        .rd_data_o  (rd_data_o)
    );

    vpic_arbiter #(.NSRC(NSRC), .NVEC(NVEC)) u_arb (
        .en_i       (en_w),
        .flg_i      (flg_w),
        .prio_i     (prio_w),
        .found_o    (found_w),
        .win_vec_o  (win_vec_w),
        .win_prio_o (win_prio_w)
    );

    // Output stage: request only above the processor's current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid_o <= 1'b0;
            irq_vec_o   <= '0;
            irq_level_o <= '0;
        end else begin
            irq_valid_o <= found_w && (win_prio_w.main > cpu_prio_i);
            irq_vec_o   <= mode_w ? win_vec_w : '0;
            irq_level_o <= win_prio_w.main;
        end
    end

    AST_VALID_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_level_o > $past(cpu_prio_i))); // R2
    AST_SINGLE_MODE_VEC0: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_w |=> (irq_vec_o == '0)); // R8
endmodule

// File: tb/vpic_top_test.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a behavioural model held in the bench.
module vpic_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16, NVEC = 8, NEXT = 5, AW = 4, DW = 32;
    localparam int VW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en_i = 1'b0;
    logic [AW-1:0]   addr_i = '0;
    logic [DW-1:0]   wdata_i = '0;
    logic [DW-1:0]   rd_data_o;
    logic [NSRC-1:0] evt_i = '0;
    logic [NEXT-1:0] ext_pin_i = '0;
    logic [2:0]      cpu_prio_i = '0;
    logic            irq_valid_o;
    logic [VW-1:0]   irq_vec_o;
    logic [2:0]      irq_level_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Bench model of register state.
    logic [NSRC-1:0] m_en = '0, m_flg = '0;
    logic [4:0]      m_prio [NVEC];
    logic            m_mode = 1'b0;
    logic [NEXT-1:0] m_pol = '0;

    vpic_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rd_data_o(rd_data_o), .evt_i(evt_i),
        .ext_pin_i(ext_pin_i), .cpu_prio_i(cpu_prio_i),
        .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o), .irq_level_o(irq_level_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        addr_i = AW'(a);
        #1 d = rd_data_o;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
        m_flg = m_flg | m;
    endtask

    task automatic set_prio(input int v, input int main, input int sub);
        m_prio[v] = 5'((main << 2) | sub);
        wr(3 + v, DW'(m_prio[v]));
    endtask

    // Expected outputs from the requirements (R2, R4, R5, R6, R8).
    task automatic model(output bit v, output int vec, output int lvl);
        logic [NVEC-1:0] act = '0;
        bit found = 0;
        int best = 0, win = 0;
        for (int s = 0; s < NSRC; s++)
            if (m_en[s] && m_flg[s]) act[(s * NVEC) / NSRC] = 1'b1;
        for (int k = 0; k < NVEC; k++)
            if (act[k] && m_prio[k][4:2] != 0 && (!found || int'(m_prio[k]) > best)) begin
                found = 1; best = int'(m_prio[k]); win = k;
            end
        lvl = found ? (best >> 2) : 0;
        v   = found && (lvl > int'(cpu_prio_i));
        vec = (found && m_mode) ? win : 0;
    endtask

    task automatic check_out(input string req);
        bit ev; int evec, elvl;
        model(ev, evec, elvl);
        chk(irq_valid_o == ev, {req, " valid"}, int'(irq_valid_o), int'(ev));
        chk(int'(irq_vec_o) == evec, {req, " vector"}, int'(irq_vec_o), evec);
        chk(int'(irq_level_o) == elvl, {req, " level"}, int'(irq_level_o), elvl);
    endtask

    task automatic check_flags(input string req);
        logic [DW-1:0] d;
        rd(1, d);
        chk(d[NSRC-1:0] == m_flg, {req, " flags"}, int'(d[NSRC-1:0]), int'(m_flg));
    endtask

    // Watchdog: counts as a failed check, still reaches the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd4242));
        for (int k = 0; k < NVEC; k++) m_prio[k] = '0;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state.
        rd(0, d); chk(d == 0, "R1 enables", int'(d), 0);
        rd(1, d); chk(d == 0, "R1 flags", int'(d), 0);
        rd(2, d); chk(d == 0, "R1 control", int'(d), 0);
        rd(3, d); chk(d == 0, "R1 prio", int'(d), 0);
        check_out("R1");

        // R2: flagged but not enabled -> no request.
        wr(2, 1); m_mode = 1'b1;
        set_prio(0, 3, 0);
        pulse(16'h0001);
        settle(4); check_out("R2 disabled");
        chk(irq_valid_o == 0, "R2 no enable", int'(irq_valid_o), 0);

        // R10: output one clock after the enable write lands.
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 0; wdata_i = 32'h1;
        @(negedge clk);
        wr_en_i = 1'b0; m_en = 16'h0001;
        chk(irq_valid_o == 0, "R10 not yet", int'(irq_valid_o), 0);
        @(negedge clk);
        chk(irq_valid_o == 1, "R10 one clock", int'(irq_valid_o), 1);
        chk(irq_level_o == 3, "R10 level", int'(irq_level_o), 3);

        // R2/R3: equal level holds back; lower level releases.
        cpu_prio_i = 3; settle(4); check_out("R2 equal");
        chk(irq_valid_o == 0, "R2 equal held", int'(irq_valid_o), 0);
        check_flags("R3 pending");
        cpu_prio_i = 2; settle(4);
        chk(irq_valid_o == 1, "R3 released", int'(irq_valid_o), 1);
        cpu_prio_i = 0;

        // R4: main level 0 disables regardless of sub-level.
        set_prio(0, 0, 3); settle(4);
        chk(irq_valid_o == 0, "R4 disabled vector", int'(irq_valid_o), 0);
        check_out("R4");

        // R5: sub-level breaks a main tie; full tie goes to the lower index.
        wr(0, 32'h0830); m_en = 16'h0830;            // sources 4,5 -> v2, 11 -> v5
        pulse(16'h0810);
        set_prio(2, 5, 1); set_prio(5, 5, 2); settle(4);
        chk(irq_vec_o == 5, "R5 higher sub", int'(irq_vec_o), 5);
        set_prio(2, 5, 2); settle(4);
        chk(irq_vec_o == 2, "R5 tie lower index", int'(irq_vec_o), 2);
        set_prio(5, 6, 0); settle(4);
        chk(irq_vec_o == 5, "R5 higher main", int'(irq_vec_o), 5);
        check_out("R5");

        // R6: clearing source 4 leaves v2 active through shared source 5.
        wr(1, 32'h0800); m_flg = m_flg & ~16'h0800;
        pulse(16'h0020); wr(1, 32'h0010); m_flg = m_flg & ~16'h0010;
        settle(4);
        chk(irq_vec_o == 2, "R6 shared vector", int'(irq_vec_o), 2);
        check_out("R6");

        // R7: write of ones to clear flags never sets; set wins over clear.
        wr(1, 32'hFFFF); m_flg = '0; check_flags("R7 clear");
        wr(1, 32'hFFFF); check_flags("R7 no set");
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 1; wdata_i = 32'h0040; evt_i = 16'h0040;
        @(negedge clk);
        wr_en_i = 1'b0; evt_i = '0; m_flg = 16'h0040;
        check_flags("R7 set wins");

        // R8: single mode reports vector 0.
        wr(0, 32'h0040); m_en = 16'h0040; set_prio(3, 4, 0);
        wr(2, 0); m_mode = 1'b0; settle(4);
        chk(irq_vec_o == 0 && irq_valid_o == 1, "R8 single", int'(irq_vec_o), 0);
        wr(2, 1); m_mode = 1'b1; settle(4);
        chk(irq_vec_o == 3, "R8 multi", int'(irq_vec_o), 3);

        // R9: pin 1 with falling polarity ignores a rise, catches a fall.
        wr(1, 32'hFFFF); m_flg = '0;
        ext_pin_i[1] = 1'b1; settle(6); check_flags("R9 rise ignored");
        ext_pin_i[1] = 1'b0; settle(6); m_flg[1] = 1'b1; check_flags("R9 fall");
        wr(2, 32'h0005); m_pol = 5'b00010;              // pin 1 rising, multi mode
        wr(1, 32'hFFFF); m_flg = '0;
        ext_pin_i[1] = 1'b1; settle(6); m_flg[1] = 1'b1; check_flags("R9 rise");
        ext_pin_i[1] = 1'b0; wr(1, 32'hFFFF); m_flg = '0; settle(6);
        check_flags("R9 fall ignored");

        // Random traffic over R2-R8.
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0: begin logic [NSRC-1:0] e = 16'($urandom); wr(0, DW'(e)); m_en = e; end
                1: pulse(16'($urandom) & 16'($urandom));
                2: begin logic [NSRC-1:0] c = 16'($urandom); wr(1, DW'(c)); m_flg = m_flg & ~c; end
                3: set_prio($urandom_range(0, NVEC-1), $urandom_range(0, 7), $urandom_range(0, 3));
                4: cpu_prio_i = 3'($urandom);
                default: begin
                    m_mode = 1'($urandom);
                    wr(2, DW'({m_pol, m_mode}));
                end
            endcase
            settle(4);
            check_out("R2-R8 random");
            if (it % 10 == 0) check_flags("R7 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule